// File: doc/BRIEF.md
# Virtual Address Translation and Protection Checker

This block resolves one memory access per cycle. It takes a 32-bit virtual address, the kind of access, the processor mode and the translation enable flag, together with the fields of the page-table entry that a lookup elsewhere has already selected. It returns either a 29-bit physical address or a fault code. The TLB storage and the exception entry sequence are outside this block. The caller supplies the hit and multiple-hit flags and the entry contents.

Some fixed address regions are never translated. They map straight to physical space once the three top address bits are dropped. Privileged code may always use these regions. Code in user mode may use only one small window near the top of the map. For translated addresses, the block builds the physical address from the frame number and the page size. It also checks the two-bit protection field against the mode and the direction of the access. The first write to a page whose dirty flag is still clear is reported as a fault of its own kind. Results are registered and appear one cycle after the request.

Top module: `vat_checker`

## Requirements
- R1: An address in 0x80000000..0xBFFFFFFF or at or above 0xE0000000, accessed in privileged mode, completes with ok and physical address = vaddr & 0x1FFFFFFF. The translation enable, hit, multiple-hit and entry fields have no effect on it.
- R2: In user mode, an untranslated-region address outside 0xE0000000..0xE4000000 (both ends inclusive) is refused. A write is refused with fault 0x060, and a read or fetch with fault 0x040. Inside that window the address completes as in R1.
- R3: With translation disabled, any other address completes with ok and physical address = vaddr & 0x1FFFFFFF, whatever the mode, protection or dirty flag.
- R4: With translation enabled, a multiple hit gives fault 0x140. This takes precedence over the miss, protection and dirty checks.
- R5: With translation enabled and no hit, the fault is 0x060 for a write and 0x040 for a read or fetch.
- R6: On a hit, the physical address is (ppn << 10) with the in-page bits cleared, ORed with the in-page bits of vaddr. Size code 0 gives 10 in-page bits, 1 gives 12, 2 gives 16 and 3 gives 20.
- R7: A fetch (access code 2'b00) in user mode from an entry whose protection bit 1 is clear gives fault 0x0A0. A privileged fetch is never refused on protection.
- R8: Data protection field: 00 allows a privileged read only, 01 allows privileged read and write, 10 allows read in either mode, 11 allows read and write in either mode. A refused read (code 2'b01, and also 2'b11) gives 0x0A0. A refused write (code 2'b10) gives 0x0C0.
- R9: A permitted write that hits an entry with the dirty flag clear gives fault 0x080. With the dirty flag set, the write completes with ok.
- R10: Results appear one cycle after in_valid, with out_valid raised for that one cycle. While out_valid is high, ok is high exactly when fault is 0. Reset clears out_valid, ok and fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| vaddr | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 read |
| priv | input | 1 | 1 = privileged mode |
| xlat_en | input | 1 | Address translation enabled |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_multi | input | 1 | Lookup found more than one matching entry |
| ent_ppn | input | 19 | Physical frame number of the entry |
| ent_size | input | 2 | Page size code |
| ent_prot | input | 2 | Protection field |
| ent_dirty | input | 1 | Page already written |
| out_valid | output | 1 | Result valid |
| ok | output | 1 | Access allowed; paddr is meaningful |
| fault | output | 12 | Fault code, 0 when ok |
| paddr | output | 29 | Physical address |

## Verification
The bench probes both edges of the user window: 0xE4000000 must pass and 0xE4000004 must be refused. A design that used an exclusive upper bound, or that forgot to refuse in user mode, would get the wrong answer at one of these edges. Each page size is tested with an address whose offset bits differ from the frame bits, so a size decoder that is off by one shows up as a wrong physical address. The bench also sets a multiple hit together with a protection fault, and a clean-page write together with a protection violation. A design with the checks in the wrong order would report the lower-priority fault in these cases. A bypass access with translation enabled and no hit checks that the region decode comes before the TLB result.

// File: rtl/vat_pkg.sv
package vat_pkg;
    localparam int VA_W     = 32;
    localparam int PA_W     = 29;
    localparam int PPN_W    = 19;
    localparam int PG_LSB   = 10;
    localparam int FAULT_W  = 12;
    localparam int OFS_W    = 5;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    localparam logic [FAULT_W-1:0] F_NONE    = 12'h000;
    localparam logic [FAULT_W-1:0] F_MISS_R  = 12'h040;
    localparam logic [FAULT_W-1:0] F_MISS_W  = 12'h060;
    localparam logic [FAULT_W-1:0] F_FIRST_W = 12'h080;
    localparam logic [FAULT_W-1:0] F_VIOL_R  = 12'h0A0;
    localparam logic [FAULT_W-1:0] F_VIOL_W  = 12'h0C0;
    localparam logic [FAULT_W-1:0] F_MULTI   = 12'h140;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       size;
        logic [1:0]       prot;
        logic             dirty;
    } pte_t;

    typedef struct packed {
        logic               ok;
        logic [FAULT_W-1:0] fault;
        logic [PA_W-1:0]    pa;
    } vat_res_t;

    // number of in-page offset bits for a size code
    function automatic logic [OFS_W-1:0] ofs_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    ofs_bits = 5'd10;
            2'd1:    ofs_bits = 5'd12;
            2'd2:    ofs_bits = 5'd16;
            default: ofs_bits = 5'd20;
        endcase
    endfunction

    function automatic logic [FAULT_W-1:0] miss_code(input acc_e a);
        miss_code = (a == ACC_WRITE) ? F_MISS_W : F_MISS_R;
    endfunction
endpackage

// File: rtl/vat_region.sv
module vat_region
    import vat_pkg::*;
#(
    parameter logic [VA_W-1:0] WIN_LO = 32'hE000_0000,
    parameter logic [VA_W-1:0] WIN_HI = 32'hE400_0000
) (
    input  logic [VA_W-1:0] va,
    input  logic            priv,
    output logic            bypass,
    output logic            refused
);
    logic in_win;

    always_comb begin
        bypass  = (va[VA_W-1 -: 2] == 2'b10) || (va[VA_W-1 -: 3] == 3'b111);
        in_win  = (va >= WIN_LO) && (va <= WIN_HI);
        refused = bypass && !priv && !in_win;
    end
endmodule

// File: rtl/vat_perm.sv
module vat_perm
    import vat_pkg::*;
(
    input  acc_e               acc,
    input  logic               priv,
    input  logic [1:0]         prot,
    input  logic               dirty,
    output logic [FAULT_W-1:0] code
);
    logic rd_ok, wr_ok;

    always_comb begin
        // prot[1]: user may access; prot[0]: writes allowed
        rd_ok = priv || prot[1];
        wr_ok = rd_ok && prot[0];
        code  = F_NONE;
        unique case (acc)
            ACC_FETCH: if (!rd_ok) code = F_VIOL_R;
            ACC_WRITE: begin
                if (!wr_ok)       code = F_VIOL_W;
                else if (!dirty)  code = F_FIRST_W;
            end
            default:   if (!rd_ok) code = F_VIOL_R;
        endcase
    end
endmodule

// File: rtl/vat_merge.sv
module vat_merge
    import vat_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [PPN_W-1:0] ppn,
    input  logic [1:0]       size,
    output logic [PA_W-1:0]  pa
);
    logic [PA_W-1:0] frame, ofs_mask;

    always_comb begin
        frame    = {ppn, {PG_LSB{1'b0}}};
        ofs_mask = (PA_W'(1) << ofs_bits(size)) - PA_W'(1);
        pa       = (frame & ~ofs_mask) | (va[PA_W-1:0] & ofs_mask);
    end
endmodule

// File: rtl/vat_checker.sv
module vat_checker
    import vat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [31:0]         vaddr,
    input  logic [1:0]          acc,
    input  logic                priv,
    input  logic                xlat_en,
    input  logic                tlb_hit,
    input  logic                tlb_multi,
    input  logic [18:0]         ent_ppn,
    input  logic [1:0]          ent_size,
    input  logic [1:0]          ent_prot,
    input  logic                ent_dirty,
    output logic                out_valid,
    output logic                ok,
    output logic [11:0]         fault,
    output logic [28:0]         paddr
);
    acc_e               acc_t;
    pte_t               pte;
    logic               bypass, refused;
    logic [FAULT_W-1:0] perm_code;
    logic [PA_W-1:0]    tlb_pa;
    vat_res_t           nxt, res_q;

    assign acc_t = acc_e'(acc);
    assign pte   = '{ppn: ent_ppn, size: ent_size, prot: ent_prot, dirty: ent_dirty};

    vat_region u_region (
        .va(vaddr), .priv(priv), .bypass(bypass), .refused(refused)
    );

    vat_perm u_perm (
        .acc(acc_t), .priv(priv), .prot(pte.prot), .dirty(pte.dirty),
        .code(perm_code)
    );

    vat_merge u_merge (
        .va(vaddr), .ppn(pte.ppn), .size(pte.size), .pa(tlb_pa)
    );

    always_comb begin
        nxt.pa    = vaddr[PA_W-1:0];
        nxt.fault = F_NONE;
        if (bypass) begin
            if (refused) nxt.fault = miss_code(acc_t);
        end else if (xlat_en) begin
            if (tlb_multi)      nxt.fault = F_MULTI;
            else if (!tlb_hit)  nxt.fault = miss_code(acc_t);
            else begin
                nxt.fault = perm_code;
                nxt.pa    = tlb_pa;
            end
        end
        nxt.ok = (nxt.fault == F_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res_q <= nxt;
        end
    end

    assign ok    = out_valid && res_q.ok;
    assign fault = out_valid ? res_q.fault : F_NONE;
    assign paddr = res_q.pa;

    // R10: one-cycle latency of the valid strobe
    a_r10_valid_lat: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r10_ok_vs_fault: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (ok == (fault == F_NONE)));
    // R2: refused user access to a fixed region reports a miss code
    a_r2_refused: assert property (@(posedge clk) disable iff (rst)
        (in_valid && refused) |=> (!ok && (fault == F_MISS_R || fault == F_MISS_W)));
    // R1: admitted fixed-region access passes the low address bits
    a_r1_bypass_pa: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bypass && !refused) |=> (ok && paddr == $past(vaddr[PA_W-1:0])));
    // R4: multiple hit dominates in translated space
    a_r4_multi: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bypass && xlat_en && tlb_multi) |=> (fault == F_MULTI));
endmodule

// File: tb/vat_checker_test.sv
module vat_checker_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] vaddr;
    logic [1:0]  acc;
    logic        priv, xlat_en, tlb_hit, tlb_multi;
    logic [18:0] ent_ppn;
    logic [1:0]  ent_size, ent_prot;
    logic        ent_dirty;
    logic        out_valid, ok;
    logic [11:0] fault;
    logic [28:0] paddr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vat_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vaddr(vaddr), .acc(acc),
        .priv(priv), .xlat_en(xlat_en), .tlb_hit(tlb_hit), .tlb_multi(tlb_multi),
        .ent_ppn(ent_ppn), .ent_size(ent_size), .ent_prot(ent_prot),
        .ent_dirty(ent_dirty), .out_valid(out_valid), .ok(ok), .fault(fault),
        .paddr(paddr)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  acc;
        logic        priv;
        logic        xen;
        logic        hit;
        logic        multi;
        logic [1:0]  sz;
        logic [1:0]  prot;
        logic        dirty;
        logic        eok;
        logic [11:0] efault;
        logic [28:0] epa;
        logic [3:0]  req;
    } vec_t;

    localparam logic [18:0] PPN = 19'h5A5A5;
    localparam int NV = 31;
    // va, acc, priv, xen, hit, multi, sz, prot, dirty, eok, efault, epa, req
    localparam vec_t VECS [NV] = '{
        '{32'h8ABCDEF0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h0ABCDEF0, 4'd1},  // R1
        '{32'hBFFFFFFF, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h1FFFFFFF, 4'd1},  // R1
        '{32'hFFFFFFFC, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h1FFFFFFC, 4'd1},  // R1
        '{32'hE0001234, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h00001234, 4'd2},  // R2
        '{32'hE4000000, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h04000000, 4'd2},  // R2
        '{32'hE4000004, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'b11, 1'b1, 1'b0, 12'h040, 29'h0, 4'd2},         // R2
        '{32'h80000000, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'b11, 1'b1, 1'b0, 12'h060, 29'h0, 4'd2},         // R2
        '{32'hA0000000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'b11, 1'b1, 1'b0, 12'h040, 29'h0, 4'd2},         // R2
        '{32'hC0001000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h00001000, 4'd3},  // R3
        '{32'h7FFFFFFF, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 1'b0, 1'b1, 12'h000, 29'h1FFFFFFF, 4'd3},  // R3
        '{32'h1234ABCD, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 2'b11, 1'b1, 1'b0, 12'h140, 29'h0, 4'd4},         // R4
        '{32'h1234ABCD, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 2'b00, 1'b0, 1'b0, 12'h140, 29'h0, 4'd4},         // R4
        '{32'h1234ABCD, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2'b11, 1'b1, 1'b0, 12'h040, 29'h0, 4'd5},         // R5
        '{32'h1234ABCD, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2'b11, 1'b1, 1'b0, 12'h060, 29'h0, 4'd5},         // R5
        '{32'h1234ABCD, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b11, 1'b1, 1'b0, 12'h040, 29'h0, 4'd5},         // R5
        '{32'h1234ABCD, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'b11, 1'b1, 1'b1, 12'h000, 29'h169697CD, 4'd6},  // R6
        '{32'h1234ABCD, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'b11, 1'b1, 1'b1, 12'h000, 29'h16969BCD, 4'd6},  // R6
        '{32'h1234ABCD, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 2'b11, 1'b1, 1'b1, 12'h000, 29'h1696ABCD, 4'd6},  // R6
        '{32'h1234ABCD, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 2'b11, 1'b1, 1'b1, 12'h000, 29'h1694ABCD, 4'd6},  // R6
        '{32'h1234ABCD, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b01, 1'b1, 1'b0, 12'h0A0, 29'h0, 4'd7},         // R7
        '{32'h1234ABCD, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b10, 1'b1, 1'b1, 12'h000, 29'h16969BCD, 4'd7},  // R7
        '{32'h1234ABCD, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'b00, 1'b0, 1'b1, 12'h000, 29'h16969BCD, 4'd7},  // R7
        '{32'h1234ABCD, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b00, 1'b1, 1'b0, 12'h0A0, 29'h0, 4'd8},         // R8
        '{32'h1234ABCD, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b01, 1'b1, 1'b0, 12'h0A0, 29'h0, 4'd8},         // R8
        '{32'h1234ABCD, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b10, 1'b1, 1'b0, 12'h0C0, 29'h0, 4'd8},         // R8
        '{32'h1234ABCD, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'b00, 1'b1, 1'b0, 12'h0C0, 29'h0, 4'd8},         // R8
        '{32'h1234ABCD, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'b01, 1'b1, 1'b1, 12'h000, 29'h16969BCD, 4'd8},  // R8
        '{32'h1234ABCD, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b10, 1'b0, 1'b1, 12'h000, 29'h16969BCD, 4'd8},  // R8
        '{32'h1234ABCD, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b11, 1'b0, 1'b0, 12'h080, 29'h0, 4'd9},         // R9
        '{32'h1234ABCD, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'b10, 1'b0, 1'b0, 12'h0C0, 29'h0, 4'd9},         // R9
        '{32'h1234ABCD, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 2'b11, 1'b1, 1'b1, 12'h000, 29'h1696ABCD, 4'd9}   // R9
    };

    task automatic drive(input vec_t v);
        vaddr     = v.va;
        acc       = v.acc;
        priv      = v.priv;
        xlat_en   = v.xen;
        tlb_hit   = v.hit;
        tlb_multi = v.multi;
        ent_ppn   = PPN;
        ent_size  = v.sz;
        ent_prot  = v.prot;
        ent_dirty = v.dirty;
    endtask

    task automatic check(input string tag, input logic good,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        fork
            begin
                rst = 1'b1; in_valid = 1'b0;
                drive('0);
                repeat (3) @(posedge clk);
                #1;
                // R10: reset state
                check("R10 reset out_valid", out_valid == 1'b0, 32'(out_valid), 32'h0);
                check("R10 reset ok", ok == 1'b0, 32'(ok), 32'h0);
                check("R10 reset fault", fault == 12'h0, 32'(fault), 32'h0);
                rst = 1'b0;

                for (int i = 0; i < NV; i++) begin
                    drive(VECS[i]);
                    in_valid = 1'b1;
                    @(posedge clk);
                    #1;
                    in_valid = 1'b0;
                    check($sformatf("R%0d vec %0d out_valid", VECS[i].req, i),
                          out_valid == 1'b1, 32'(out_valid), 32'h1);
                    check($sformatf("R%0d vec %0d ok", VECS[i].req, i),
                          ok == VECS[i].eok, 32'(ok), 32'(VECS[i].eok));
                    check($sformatf("R%0d vec %0d fault", VECS[i].req, i),
                          fault == VECS[i].efault, 32'(fault), 32'(VECS[i].efault));
                    if (VECS[i].eok)
                        check($sformatf("R%0d vec %0d paddr", VECS[i].req, i),
                              paddr == VECS[i].epa, 32'(paddr), 32'(VECS[i].epa));
                end

                // R10: strobe lasts one cycle when no new request follows
                @(posedge clk);
                #1;
                check("R10 idle out_valid", out_valid == 1'b0, 32'(out_valid), 32'h0);
                check("R10 idle fault", fault == 12'h0, 32'(fault), 32'h0);

                // R10: back-to-back requests, fault then pass
                drive(VECS[5]);
                in_valid = 1'b1;
                @(posedge clk);
                #1;
                check("R10 b2b first fault", fault == 12'h040, 32'(fault), 32'h040);
                drive(VECS[0]);
                @(posedge clk);
                #1;
                in_valid = 1'b0;
                check("R10 b2b second ok", ok == 1'b1, 32'(ok), 32'h1);
                check("R10 b2b second paddr", paddr == 29'h0ABCDEF0, 32'(paddr), 32'h0ABCDEF0);

                // R10: reset mid-stream clears outputs
                drive(VECS[12]);
                in_valid = 1'b1;
                rst = 1'b1;
                @(posedge clk);
                #1;
                in_valid = 1'b0;
                check("R10 reset clears valid", out_valid == 1'b0, 32'(out_valid), 32'h0);
                check("R10 reset clears fault", fault == 12'h0, 32'(fault), 32'h0);
                rst = 1'b0;
                @(posedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule